// File: doc/BRIEF.md
# Per-Channel Load Fault Gate Controller

This block drives the gate of one external low-side power switch and judges the health of its load from a single digital comparator flag. The flag says whether the drain node sits above the fault reference. The channel is switched on by either of two commands. One is a bit held by the serial control path. The other is a parallel input that needs neither clock nor select. The block instance for one channel is placed once per output.

While the gate is on, a drain that stays high means the load is shorted. While the gate is off, a drain that sits low means the load is open. Every change of the gate starts a settling window during which the comparator is ignored. A mode input picks the reaction to a short. In latch-off mode the channel stays off until its command is dropped and given again. In retry mode the channel runs a slow, low-duty pulse train until the short clears or the command goes away. The fault output is a live level: it shows the present condition and leaves capture to the serial interface.

All time intervals are counted in system clocks. Battery lockout and reset both force the gate off.

Top module: `load_fault_gate_ctrl`

## Requirements
- R1: The channel is commanded on when `ser_cmd_i` or `par_cmd_i` is 1. In normal operation `gate_o` takes the command value one clock after it is sampled.
- R2: Each change of `gate_o`, and the release of reset, starts a window of MASK_CYC clocks. During this window `drain_high_i` has no effect on `fault_o` or `gate_o`.
- R3: With the gate on and the window over, a short is declared only after `drain_high_i` is 1 on DEGLITCH_CYC consecutive clocks. Any low clock restarts the count.
- R4: With the gate off and the window over, `drain_high_i` = 0 sets `fault_o` = 1 in the same cycle (open load), and `drain_high_i` = 1 clears it in the same cycle.
- R5: In latch-off mode (`retry_mode_i` = 0), a short drives `gate_o` to 0 on the next clock and holds `fault_o` at 1. This lasts until the command has gone to 0 and then back to 1. The return to 1 turns the gate on with no fault.
- R6: In retry mode (`retry_mode_i` = 1), a short turns the gate off for RETRY_PERIOD_CYC−RETRY_ON_CYC clocks. It then turns it on for up to RETRY_ON_CYC clocks, and this repeats. The same window and deglitch apply in each pulse, and a short detected inside a pulse ends that pulse at once. `fault_o` stays 1 throughout.
- R7: In retry mode, a pulse that completes without a short returns the channel to normal on-state with `fault_o` = 0. Removing the command exits retry with the gate off.
- R8: `lockout_i` = 1 forces `gate_o` to 0 on the next clock and holds `fault_o` at 0.
- R9: While `rst_ni` is 0, `gate_o` and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_cmd_i | input | 1 | Channel bit from the serial control register |
| par_cmd_i | input | 1 | Direct parallel channel command |
| lockout_i | input | 1 | Battery out-of-range lockout |
| retry_mode_i | input | 1 | 0: latch off on short, 1: pulsed retry |
| drain_high_i | input | 1 | Comparator: drain above fault reference |
| gate_o | output | 1 | Gate enable to the driver stage |
| fault_o | output | 1 | Live channel fault |

## Verification
The bench builds the block with MASK_CYC = 6, DEGLITCH_CYC = 3, RETRY_PERIOD_CYC = 40 and RETRY_ON_CYC = 12. These values keep every window a handful of clocks long. Exact-edge checks therefore fit easily: one clock before and one clock after a trip, a mask that hides an open load for exactly its length, and a deglitch restart. The short period also lets several full retry periods run in one pass, including a pulse cut short by a persisting short and a clean pulse that restores the channel. The defaults keep RETRY_ON_CYC equal to MASK_CYC + DEGLITCH_CYC, the least value at which a pulse can still detect a short.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_TRIP  = 2'd1,
    ST_REARM = 2'd2,
    ST_RETRY = 2'd3
  } lfg_state_e;
endpackage

// File: rtl/lfg_settle_mask.sv
module lfg_settle_mask #(
  parameter int unsigned MASK_CYC = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(MASK_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= CW'(MASK_CYC);
    else if (restart_i)         cnt_q <= CW'(MASK_CYC);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  AST_MASK_AFTER_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> active_o) else $error("mask not open after gate change"); // R2
endmodule

// File: rtl/lfg_deglitch.sv
module lfg_deglitch #(
  parameter int unsigned DEGLITCH_CYC = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic level_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(DEGLITCH_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run;

  assign run   = armed_i & level_i;
  assign hit_o = run & (cnt_q == CW'(DEGLITCH_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (hit_o)   cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_DG_CONSECUTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && DEGLITCH_CYC > 1) |-> $past(armed_i && level_i)) else $error("deglitch broke"); // R3
endmodule

// File: rtl/lfg_retry_timer.sv
module lfg_retry_timer #(
  parameter int unsigned RETRY_PERIOD_CYC = 1000000,
  parameter int unsigned RETRY_ON_CYC     = 6800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  output logic on_next_o,
  output logic last_o
);
  localparam int unsigned CW      = $clog2(RETRY_PERIOD_CYC);
  localparam int unsigned OFF_CYC = RETRY_PERIOD_CYC - RETRY_ON_CYC;

  logic [CW-1:0] cnt_q, cnt_nxt, cnt_eff;

  assign last_o    = (cnt_q == CW'(RETRY_PERIOD_CYC - 1));
  assign cnt_nxt   = last_o ? '0 : cnt_q + 1'b1;
  assign cnt_eff   = hold_i ? cnt_q : cnt_nxt;
  assign on_next_o = (cnt_eff >= CW'(OFF_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start_i)  cnt_q <= '0;
    else if (!hold_i)  cnt_q <= cnt_nxt;
  end

  AST_RT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !start_i) |=> $stable(cnt_q)) else $error("retry timer moved in lockout"); // R8
endmodule

// File: rtl/load_fault_gate_ctrl.sv
module load_fault_gate_ctrl
  import lfg_pkg::*;
#(
  parameter int unsigned MASK_CYC         = 6000,
  parameter int unsigned DEGLITCH_CYC     = 800,
  parameter int unsigned RETRY_PERIOD_CYC = 1000000,
  parameter int unsigned RETRY_ON_CYC     = 6800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_cmd_i,
  input  logic par_cmd_i,
  input  logic lockout_i,
  input  logic retry_mode_i,
  input  logic drain_high_i,
  output logic gate_o,
  output logic fault_o
);
  localparam int unsigned OW = $clog2(RETRY_ON_CYC + 2);

  lfg_state_e state_q, state_d;
  logic gate_q, gate_d;
  logic cmd_w, mask_active, armed, short_det, open_flt;
  logic rt_start, rt_on_next, rt_last, sticky_flt;

  assign cmd_w = ser_cmd_i | par_cmd_i;

  lfg_settle_mask #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk_i, .rst_ni, .restart_i(gate_d != gate_q), .active_o(mask_active)
  );

  assign armed = gate_q & ~mask_active;

  lfg_deglitch #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_dg (
    .clk_i, .rst_ni, .armed_i(armed), .level_i(drain_high_i), .hit_o(short_det)
  );

  lfg_retry_timer #(.RETRY_PERIOD_CYC(RETRY_PERIOD_CYC), .RETRY_ON_CYC(RETRY_ON_CYC)) u_rt (
    .clk_i, .rst_ni, .start_i(rt_start), .hold_i(lockout_i),
    .on_next_o(rt_on_next), .last_o(rt_last)
  );

  always_comb begin
    state_d  = state_q;
    gate_d   = 1'b0;
    rt_start = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        gate_d = cmd_w & ~lockout_i;
        if (short_det) begin
          gate_d   = 1'b0;
          rt_start = 1'b1;
          state_d  = retry_mode_i ? ST_RETRY : ST_TRIP;
        end
      end
      ST_TRIP: if (!cmd_w) state_d = ST_REARM;
      ST_REARM: begin
        gate_d = cmd_w & ~lockout_i;
        if (cmd_w) state_d = ST_RUN;
      end
      ST_RETRY: begin
        if (!cmd_w) begin
          state_d = ST_RUN;
        end else if (short_det) begin
          rt_start = 1'b1;                  // cut pulse, new period
        end else if (rt_last && gate_q) begin
          state_d = ST_RUN;                 // clean pulse: resume
          gate_d  = ~lockout_i;
        end else begin
          gate_d = rt_on_next & ~lockout_i;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= gate_d;
    end
  end

  assign open_flt   = ~gate_q & ~mask_active & ~drain_high_i;
  assign sticky_flt = (state_q != ST_RUN);
  assign gate_o     = gate_q;
  assign fault_o    = ~lockout_i & (sticky_flt | open_flt);

  // pulse-width monitor for the retry train
  logic [OW-1:0] on_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                on_run_q <= '0;
    else if (gate_q && state_q == ST_RETRY) begin
      if (on_run_q != OW'(RETRY_ON_CYC + 1))    on_run_q <= on_run_q + 1'b1;
    end else                                    on_run_q <= '0;
  end

  AST_CMD_OFF_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_w |=> !gate_o) else $error("gate on without command"); // R1
  AST_LOCKOUT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> !gate_o) else $error("gate on in lockout"); // R8
  AST_TRIP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_q) && $past(state_q) == ST_RUN && $past(cmd_w) && !$past(lockout_i))
      |-> $past(drain_high_i)) else $error("trip without high drain"); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRIP) |=> !gate_o) else $error("latched channel turned on"); // R5
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RETRY) |-> on_run_q <= OW'(RETRY_ON_CYC)) else $error("retry pulse too long"); // R6
endmodule

// File: tb/load_fault_gate_ctrl_tb.sv
`timescale 1ns/1ps
module load_fault_gate_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 0, par = 0, lock = 0, rtry = 0, drn = 1;
  logic gate, fault;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  load_fault_gate_ctrl #(
    .MASK_CYC(6), .DEGLITCH_CYC(3), .RETRY_PERIOD_CYC(40), .RETRY_ON_CYC(12)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_cmd_i(ser), .par_cmd_i(par),
    .lockout_i(lock), .retry_mode_i(rtry), .drain_high_i(drn),
    .gate_o(gate), .fault_o(fault)
  );

  // {ser,par,lock,retry,drain,hold[7:0],exp_gate,exp_fault,req[3:0]}
  function automatic logic [18:0] mk(int s, int p, int l, int r, int d, int h, int eg, int ef, int rq);
    return {s[0], p[0], l[0], r[0], d[0], h[7:0], eg[0], ef[0], rq[3:0]};
  endfunction

  localparam int NV = 26;
  localparam logic [18:0] VEC [NV] = '{
    mk(0,0,0,0,1,10,0,0,1),  // R1 idle off, no fault
    mk(0,0,0,0,0, 1,0,1,4),  // R4 open load seen
    mk(0,0,0,0,1, 1,0,0,4),  // R4 live, clears
    mk(0,1,0,0,0, 1,1,0,1),  // R1 parallel on
    mk(0,1,0,0,1, 7,1,0,2),  // R2 mask then partial deglitch
    mk(0,1,0,0,0, 1,1,0,3),  // R3 low restarts count
    mk(0,1,0,0,1, 2,1,0,3),  // R3 one short of trip
    mk(0,1,0,0,1, 1,0,1,5),  // R5 trip
    mk(0,1,0,0,1,20,0,1,5),  // R5 stays latched
    mk(0,0,0,0,1, 3,0,1,5),  // R5 command off, still flagged
    mk(0,1,0,0,0, 1,1,0,5),  // R5 re-command clears
    mk(1,0,0,0,0, 3,1,0,1),  // R1 serial holds on
    mk(0,0,0,0,1, 1,0,0,1),  // R1 off
    mk(0,0,0,0,0, 1,0,0,2),  // R2 open hidden by mask
    mk(0,0,0,0,0, 5,0,1,4),  // R4 mask over, open seen
    mk(0,0,0,0,1, 1,0,0,4),
    mk(1,0,1,0,0, 3,0,0,8),  // R8 lockout: off, fault hidden
    mk(1,0,0,0,0, 1,1,0,8),  // R8 release
    mk(1,0,0,1,1, 9,0,1,6),  // R6 short enters retry
    mk(1,0,0,1,1,28,1,1,6),  // R6 off phase ends, pulse on
    mk(1,0,0,1,1, 8,1,1,6),  // R6 pulse still on
    mk(1,0,0,1,1, 1,0,1,6),  // R6 pulse cut by short
    mk(1,0,0,1,0,28,1,1,7),  // R7 next pulse, short gone
    mk(1,0,0,1,0,12,1,0,7),  // R7 clean pulse resumes
    mk(1,0,0,1,1, 3,0,1,7),  // R7 short again
    mk(0,0,0,1,1, 2,0,0,7)   // R7 command removed
  };

  task automatic chk(int rq, int idx, logic eg, logic ef);
    n_chk++;
    if (gate !== eg || fault !== ef) begin
      n_bad++;
      $display("FAIL R%0d step %0d: gate=%b exp %b, fault=%b exp %b", rq, idx, gate, eg, fault, ef);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(9, -1, 0, 0);                           // R9 in reset
    rst_n = 1'b1;
    foreach (VEC[i]) begin
      {ser, par, lock, rtry, drn} = VEC[i][18:14];
      repeat (int'(VEC[i][13:6])) @(posedge clk);
      @(negedge clk);
      chk(int'(VEC[i][3:0]), i, VEC[i][5], VEC[i][4]);
    end
    // R9: reset while on
    rtry = 0; ser = 1; drn = 0;
    @(posedge clk); @(negedge clk);
    chk(1, 100, 1, 0);
    rst_n = 1'b0; ser = 0; #1;
    chk(9, 101, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    // R2: mask runs after reset release, drain low hidden
    repeat (5) @(posedge clk); @(negedge clk);
    chk(2, 102, 0, 0);
    @(posedge clk); @(negedge clk);
    chk(4, 103, 0, 1);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, exp completion");
      finish_run();
    end
  end
endmodule